// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block keeps the floating-point status/control word of a processor and turns the raw exception flags of each completed arithmetic operation into the register's flag, cause and trap behaviour. Software loads the word through a write port. The arithmetic unit reports each finished operation with a strobe and a five-bit flag vector. A compare that finds its operands unordered reports through the same path. The block returns the stored word, the rounding direction decoded from it and a flush-to-zero enable. When an enabled exception is pending it also raises a trap request that carries a fixed exception code.

All outputs are registered. A write, an operation update and the trap that update produces all become visible on the clock edge that samples the strobe. That is one cycle after the strobe is presented.

Top module: `fp_status_ctrl`

## Requirements
- R1: After synchronous reset the stored word is 0, and `trap_req_o`, `rz_mode_o`, `ftz_en_o` and `trap_code_o` are all 0.
- R2: A write stores `wr_data` AND 0x0005FFFF. Bit 17 and bits 31..19 always read as 0. The new word is visible on `csr_o` one cycle after `wr_en`.
- R3: The rounding field is bits [1:0]. `rz_mode_o` is 1 (round toward zero) only when this field is 01. The values 00, 10 and 11 give 0 (round to nearest even).
- R4: `ftz_en_o` equals the denormal-control bit, which is bit 18 of the stored word.
- R5: An operation update replaces the flag field, bits [6:2], with `op_flags`. Input bit k goes to register bit 2+k, in the order inexact (k=0), underflow (1), overflow (2), divide-by-zero (3), invalid (4). The rounding bits, the enable bits [11:7] and bit 18 are kept.
- R6: On an update with nonzero flags, `op_flags` is OR-ed into the cause field, bits [16:12], at register bit 12+k. Cause bits are cleared only by a write.
- R7: If an update with nonzero flags leaves (cause AND enable) nonzero, with enable bit 7+k pairing with cause bit 12+k, then `trap_req_o` is 1 for that one cycle and `trap_code_o` is 0x120. In every other cycle `trap_req_o` is 0 and `trap_code_o` is 0. A cause bit left set by an earlier operation still traps on a later nonzero update.
- R8: An update with all-zero flags clears the flag field, leaves the cause field unchanged and raises no trap, even when a cause bit and its enable bit are both set.
- R9: A compare strobe with `cmp_unord`=1 performs the same update as `op_valid`, using `op_flags`. A compare strobe with `cmp_unord`=0 leaves the word unchanged and raises no trap.
- R10: When `wr_en` and an update strobe arrive in the same cycle, the write is stored, the update is dropped and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| op_valid | input | 1 | Operation completed strobe |
| op_flags | input | 5 | Raised exceptions: [0] inexact, [1] underflow, [2] overflow, [3] divide-by-zero, [4] invalid |
| cmp_valid | input | 1 | Compare completed strobe |
| cmp_unord | input | 1 | Compare result was unordered |
| csr_o | output | 32 | Stored status/control word |
| rz_mode_o | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| ftz_en_o | output | 1 | Flush-to-zero enable |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_code_o | output | 12 | Exception code while trapping, else 0 |

## Verification
All state of this block is the stored word, and that word is visible on `csr_o` every cycle. A wrong flag, cause or enable bit therefore shows on the port one cycle after the strobe that produced it. A corrupted cause bit does more harm than a wrong flag bit, because it persists. It can cause a spurious trap or a missed trap on any later operation, long after the fault, so the bench compares the whole word against its model on every clock. The decoded rounding and flush outputs come from the same next value as the word. A mismatch between them and `csr_o` appears in the same cycle.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  // Build a contiguous bit mask of width w starting at bit lo.
  function automatic longint unsigned field_mask(input int lo, input int w);
    longint unsigned m;
    m = 0;
    for (int i = 0; i < w; i++) m = m | (64'd1 << (lo + i));
    return m;
  endfunction
endpackage

// File: rtl/fpsc_exc_merge.sv
// Per-exception merge of new flags into the sticky cause field and
// detection of an enabled pending cause.
module fpsc_exc_merge #(
  parameter int EXC_N = 5
) (
  input  logic [EXC_N-1:0] flags_in,
  input  logic [EXC_N-1:0] cause_old,
  input  logic [EXC_N-1:0] enable,
  output logic [EXC_N-1:0] cause_new,
  output logic             trap_hit
);
  logic [EXC_N-1:0] hit;

  for (genvar k = 0; k < EXC_N; k++) begin : g_bit
    assign cause_new[k] = cause_old[k] | flags_in[k];
    assign hit[k]       = cause_new[k] & enable[k];
  end

  // A trap is only evaluated when the operation raised something.
  assign trap_hit = (|flags_in) & (|hit);
endmodule

// File: rtl/fpsc_round_dec.sv
// Rounding-field decode: one code selects toward-zero, all others nearest-even.
module fpsc_round_dec #(
  parameter int          RM_W    = 2,
  parameter logic [RM_W-1:0] RZ_CODE = 1
) (
  input  logic [RM_W-1:0] rm_field,
  output logic            rz_sel
);
  assign rz_sel = (rm_field == RZ_CODE);
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsc_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              EXC_N     = 5,
  parameter int              RM_W      = 2,
  parameter int              RM_LO     = 0,
  parameter int              FLAG_LO   = 2,
  parameter int              EN_LO     = 7,
  parameter int              CAUSE_LO  = 12,
  parameter int              DN_BIT    = 18,
  parameter int              CODE_W    = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120,
  parameter logic [RM_W-1:0]   RZ_CODE   = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_valid,
  input  logic [EXC_N-1:0]  op_flags,
  input  logic              cmp_valid,
  input  logic              cmp_unord,
  output logic [DATA_W-1:0] csr_o,
  output logic              rz_mode_o,
  output logic              ftz_en_o,
  output logic              trap_req_o,
  output logic [CODE_W-1:0] trap_code_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(
      field_mask(RM_LO, RM_W) | field_mask(FLAG_LO, EXC_N) |
      field_mask(EN_LO, EXC_N) | field_mask(CAUSE_LO, EXC_N) |
      field_mask(DN_BIT, 1));

  logic [DATA_W-1:0] csr_q, csr_d;
  logic              trap_q, trap_d;
  logic [CODE_W-1:0] code_q;
  logic              rz_q, rz_d;
  logic              ftz_q;
  logic              upd_fire;
  logic [EXC_N-1:0]  cause_new;
  logic              trap_hit;

  assign upd_fire = op_valid | (cmp_valid & cmp_unord);

  fpsc_exc_merge #(.EXC_N(EXC_N)) u_merge (
    .flags_in  (op_flags),
    .cause_old (csr_q[CAUSE_LO +: EXC_N]),
    .enable    (csr_q[EN_LO +: EXC_N]),
    .cause_new (cause_new),
    .trap_hit  (trap_hit)
  );

  // Next-state selection: a write overrides any update in the same cycle.
  always_comb begin
    csr_d  = csr_q;
    trap_d = 1'b0;
    if (wr_en) begin
      csr_d = wr_data & IMPL_MASK;
    end else if (upd_fire) begin
      csr_d[FLAG_LO +: EXC_N] = op_flags;
      if (|op_flags) begin
        csr_d[CAUSE_LO +: EXC_N] = cause_new;
        trap_d = trap_hit;
      end
    end
  end

  // Decode from the next value so the mode outputs stay aligned with csr_o.
  fpsc_round_dec #(.RM_W(RM_W), .RZ_CODE(RZ_CODE)) u_rdec (
    .rm_field (csr_d[RM_LO +: RM_W]),
    .rz_sel   (rz_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
      code_q <= '0;
      rz_q   <= 1'b0;
      ftz_q  <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      trap_q <= trap_d;
      code_q <= trap_d ? TRAP_CODE : '0;
      rz_q   <= rz_d;
      ftz_q  <= csr_d[DN_BIT];
    end
  end

  assign csr_o       = csr_q;
  assign rz_mode_o   = rz_q;
  assign ftz_en_o    = ftz_q;
  assign trap_req_o  = trap_q;
  assign trap_code_o = code_q;

  // ---------------- assertions ----------------
  assert_write_store_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> csr_q == ($past(wr_data) & IMPL_MASK));

  assert_round_decode_R3: assert property (@(posedge clk) disable iff (rst)
    rz_q == (csr_q[RM_LO +: RM_W] == RZ_CODE));

  assert_ftz_follow_R4: assert property (@(posedge clk) disable iff (rst)
    ftz_q == csr_q[DN_BIT]);

  assert_flags_load_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !wr_en) |=> csr_q[FLAG_LO +: EXC_N] == $past(op_flags));

  assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((csr_q[CAUSE_LO +: EXC_N] & $past(csr_q[CAUSE_LO +: EXC_N]))
                == $past(csr_q[CAUSE_LO +: EXC_N])));

  assert_trap_origin_R7: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ($past(upd_fire && !wr_en && (|op_flags)) && code_q == TRAP_CODE));

  assert_zero_flags_no_trap_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !wr_en && op_flags == '0) |=> !trap_q);

  assert_ordered_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_unord && !op_valid && !wr_en) |=> ($stable(csr_q) && !trap_q));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !trap_q);
endmodule

// File: tb/fp_status_ctrl_bench.sv
`timescale 1ns/1ps
module fp_status_ctrl_bench;
  localparam logic [31:0] MASK = 32'h0005FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        cmp_valid = 1'b0;
  logic        cmp_unord = 1'b0;
  logic [31:0] csr_o;
  logic        rz_mode_o, ftz_en_o, trap_req_o;
  logic [11:0] trap_code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_status_ctrl u_fp_status_ctrl (
    .clk, .rst, .wr_en, .wr_data, .op_valid, .op_flags,
    .cmp_valid, .cmp_unord, .csr_o, .rz_mode_o, .ftz_en_o,
    .trap_req_o, .trap_code_o
  );

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] m_csr = '0;
  bit          m_trap = 1'b0;
  always @(posedge clk) begin
    logic [31:0] fl;
    if (rst) begin
      m_csr = '0;
      m_trap = 1'b0;
    end else begin
      m_trap = 1'b0;
      fl = {27'd0, op_flags};
      if (wr_en) m_csr = wr_data & MASK;
      else if (op_valid || (cmp_valid && cmp_unord)) begin
        m_csr = (m_csr & ~32'h0000007C) | (fl << 2);
        if (fl != 0) begin
          m_csr = m_csr | (fl << 12);
          if ((((m_csr >> 12) & (m_csr >> 7)) & 32'h1F) != 0) m_trap = 1'b1;
        end
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // Every-clock comparison against the model.
  always @(negedge clk) if (live && !done) begin
    check("R2", "csr", csr_o, m_csr);
    check("R3", "rz", {31'd0, rz_mode_o}, {31'd0, m_csr[1:0] == 2'b01});
    check("R4", "ftz", {31'd0, ftz_en_o}, {31'd0, m_csr[18]});
    check("R7", "trap", {31'd0, trap_req_o}, {31'd0, m_trap});
    check("R7", "code", {20'd0, trap_code_o}, m_trap ? 32'h120 : 32'h0);
  end

  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] f);
    op_valid = 1'b1; op_flags = f;
    @(negedge clk);
    op_valid = 1'b0; op_flags = '0;
  endtask

  task automatic do_cmp(input bit unord, input logic [4:0] f);
    cmp_valid = 1'b1; cmp_unord = unord; op_flags = f;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_unord = 1'b0; op_flags = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "csr", csr_o, 32'h0);
    check("R1", "trap", {31'd0, trap_req_o}, 32'h0);
    check("R1", "rz", {31'd0, rz_mode_o}, 32'h0);
    check("R1", "ftz", {31'd0, ftz_en_o}, 32'h0);
    check("R1", "code", {20'd0, trap_code_o}, 32'h0);
    live = 1'b1;

    // R2 masking, R3 field 11, R4 bit 18 set
    do_write(32'hFFFFFFFF);
    check("R2", "masked write", csr_o, 32'h0005FFFF);
    check("R3", "rm=11", {31'd0, rz_mode_o}, 32'h0);
    check("R4", "ftz on", {31'd0, ftz_en_o}, 32'h1);
    do_write(32'h00000001);
    check("R3", "rm=01", {31'd0, rz_mode_o}, 32'h1);
    check("R4", "ftz off", {31'd0, ftz_en_o}, 32'h0);
    do_write(32'h00000002);
    check("R3", "rm=10", {31'd0, rz_mode_o}, 32'h0);

    // enable divide-by-zero (bit 10) with flush on
    do_write(32'h00040400);
    do_op(5'b00001);
    check("R5", "inexact flag", csr_o, 32'h00041404);
    check("R7", "no trap", {31'd0, trap_req_o}, 32'h0);
    do_op(5'b00100);
    check("R6", "sticky cause", csr_o, 32'h00045410);
    do_op(5'b01000);
    check("R5", "div0 flag", csr_o, 32'h0004D420);
    check("R7", "trap pulse", {31'd0, trap_req_o}, 32'h1);
    check("R7", "trap code", {20'd0, trap_code_o}, 32'h120);
    @(negedge clk);
    check("R7", "pulse ends", {31'd0, trap_req_o}, 32'h0);
    do_op(5'b00000);
    check("R8", "zero flags csr", csr_o, 32'h0004D400);
    check("R8", "zero flags no trap", {31'd0, trap_req_o}, 32'h0);
    do_op(5'b00001);
    check("R7", "stale cause traps", {31'd0, trap_req_o}, 32'h1);
    check("R6", "cause kept", csr_o, 32'h0004D404);

    // R9 compares
    do_write(32'h0);
    do_cmp(1'b0, 5'b10000);
    check("R9", "ordered compare", csr_o, 32'h0);
    do_cmp(1'b1, 5'b10000);
    check("R9", "unordered compare", csr_o, 32'h00010040);

    // R10 write wins over simultaneous update
    wr_en = 1'b1; wr_data = 32'h00000800; op_valid = 1'b1; op_flags = 5'b10000;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0; op_flags = '0;
    check("R10", "write wins", csr_o, 32'h00000800);
    check("R10", "no trap", {31'd0, trap_req_o}, 32'h0);
    do_op(5'b10000);
    check("R7", "invalid trap", {31'd0, trap_req_o}, 32'h1);
    check("R6", "invalid cause", csr_o, 32'h00010840);

    // random traffic, compared by the per-clock model
    for (int i = 0; i < 400; i++) begin
      wr_en     = ($urandom % 8) == 0;
      wr_data   = $urandom;
      op_valid  = ($urandom % 3) == 0;
      cmp_valid = ($urandom % 4) == 0;
      cmp_unord = $urandom % 2;
      op_flags  = 5'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0; op_valid = 1'b0; cmp_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule